// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block holds the interrupt and status state of every channel of a multi-channel DMA controller. Each channel engine sends it single-cycle event pulses (count reached zero, reload completed, timeout, bus abort) and a level that tells whether the channel is running. The block latches these events into sticky per-channel flags. It derives a per-channel pending bit from the flags and the channel's own event enables. It then gates that pending bit with a per-channel global enable to form the controller's interrupt vector.

When a channel stops running, the block asks the channel logic to drop its enable bit. A bus abort makes the same request. Software reads an eight-bit status word per channel. It clears the sticky flags by writing ones to them through a simple write port that selects a channel.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset, every status word is 0, `irq_o` is 0 and `en_clr_o` is 0 while all inputs are low.
- R2: A `ctz_evt_i` pulse sets status bit 2 (count-zero flag) at the next clock edge. If `ctz_ie_i` is 1 for that channel, status bit 1 (pending) is set at the same edge.
- R3: When `ch_active_i` falls from 1 to 0, `en_clr_o` is high in that same cycle. At the next edge status bit 5 (halt flag) is set, and pending is set if `dis_ie_i` is 1.
- R4: A `abort_evt_i` pulse raises `en_clr_o` in the same cycle and sets status bit 4 (bus-error flag) at the next edge. It counts toward pending only while `dis_ie_i` is 1.
- R5: A `rld_evt_i` pulse sets status bit 3 and a `to_evt_i` pulse sets status bit 6. The reload flag counts toward pending under `ctz_ie_i`, and the timeout flag counts toward pending under `dis_ie_i`.
- R6: Status bit 0 (active) follows `ch_active_i` with one cycle of delay.
- R7: A write with `wr_en_i` high clears, in channel `wr_ch_i` only, each of status bits 2 to 6 whose `wr_data_i` bit is 1. Writing 1 to bits 0, 1 or 7 has no effect, and other channels are not touched.
- R8: If an event pulse and a write that clears the same flag arrive in the same cycle, the flag stays set.
- R9: `irq_o[c]` is 1 exactly when `glb_ie_i[c]` is 1 and channel c's pending bit is 1.
- R10: Pending stays set until every flag that counts toward it has been cleared. It drops at the same edge at which the last such flag is cleared.
- R11: An event whose enable is 0 sets its flag but does not set pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_active_i | input | NUM_CH | Running level of each channel |
| ctz_evt_i | input | NUM_CH | Count-reached-zero pulses |
| rld_evt_i | input | NUM_CH | Reload-done pulses |
| to_evt_i | input | NUM_CH | Timeout pulses |
| abort_evt_i | input | NUM_CH | Bus abort pulses |
| ctz_ie_i | input | NUM_CH | Per-channel count-zero interrupt enable |
| dis_ie_i | input | NUM_CH | Per-channel stop interrupt enable |
| glb_ie_i | input | NUM_CH | Per-channel global interrupt enable |
| wr_en_i | input | 1 | Status write strobe |
| wr_ch_i | input | CH_W | Channel selected by the write |
| wr_data_i | input | 8 | Write-one-to-clear mask for the status word |
| st_o | output | NUM_CH*8 | Status words, channel c at bits [8c+7:8c] |
| irq_o | output | NUM_CH | Global interrupt vector |
| en_clr_o | output | NUM_CH | Request to clear each channel's enable |

## Verification
The two functions that can fall in the same cycle are the latching of an event into a flag and the software write that clears that flag. The bench first leaves a count-zero flag set. It then pulses the same event in the same cycle that a clear write to that bit is driven. It judges the result by reading back status bit 2 and the pending bit, both of which must stay set. A second case clears only some flags of one channel while another channel holds its own flags. Here the bench checks that pending and the global bit of the first channel persist until the last counting flag is gone.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int ST_W   = 8;
   localparam int B_ACT  = 0;
   localparam int B_PEND = 1;
   localparam int B_CTZ  = 2;
   localparam int B_RLD  = 3;
   localparam int B_BUS  = 4;
   localparam int B_HALT = 5;
   localparam int B_TO   = 6;
   localparam logic [ST_W-1:0] W1C_MASK = 8'b0111_1100;
endpackage

// File: rtl/dma_irq_wdec.sv
module dma_irq_wdec
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                           wr_en_i,
   input  logic [CH_W-1:0]                wr_ch_i,
   input  logic [ST_W-1:0]                wr_data_i,
   output logic [NUM_CH-1:0][ST_W-1:0]    clr_o
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      always_comb begin
         if (wr_en_i && (wr_ch_i == CH_W'(c)))
            clr_o[c] = wr_data_i & W1C_MASK;
         else
            clr_o[c] = '0;
      end
   end
endmodule

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
   import dma_irq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            act_i,
   input  logic            ctz_i,
   input  logic            rld_i,
   input  logic            to_i,
   input  logic            abort_i,
   input  logic            ctz_ie_i,
   input  logic            dis_ie_i,
   input  logic [ST_W-1:0] clr_i,
   output logic [ST_W-1:0] st_o,
   output logic            pend_o,
   output logic            en_clr_o
);
   logic act_q, pend_q;
   logic ctz_f, rld_f, bus_f, halt_f, to_f;
   logic ctz_n, rld_n, bus_n, halt_n, to_n, pend_n;
   logic fall;

   assign fall = act_q & ~act_i;

   always_comb begin
      ctz_n  = ctz_i   | (ctz_f  & ~clr_i[B_CTZ]);
      rld_n  = rld_i   | (rld_f  & ~clr_i[B_RLD]);
      bus_n  = abort_i | (bus_f  & ~clr_i[B_BUS]);
      halt_n = fall    | (halt_f & ~clr_i[B_HALT]);
      to_n   = to_i    | (to_f   & ~clr_i[B_TO]);
      pend_n = (ctz_ie_i & (ctz_n | rld_n)) |
               (dis_ie_i & (halt_n | bus_n | to_n));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         pend_q <= 1'b0;
         ctz_f  <= 1'b0;
         rld_f  <= 1'b0;
         bus_f  <= 1'b0;
         halt_f <= 1'b0;
         to_f   <= 1'b0;
      end else begin
         act_q  <= act_i;
         pend_q <= pend_n;
         ctz_f  <= ctz_n;
         rld_f  <= rld_n;
         bus_f  <= bus_n;
         halt_f <= halt_n;
         to_f   <= to_n;
      end
   end

   always_comb begin
      st_o         = '0;
      st_o[B_ACT]  = act_q;
      st_o[B_PEND] = pend_q;
      st_o[B_CTZ]  = ctz_f;
      st_o[B_RLD]  = rld_f;
      st_o[B_BUS]  = bus_f;
      st_o[B_HALT] = halt_f;
      st_o[B_TO]   = to_f;
   end

   assign pend_o   = pend_q;
   assign en_clr_o = fall | abort_i;

   // R2
   ctz_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctz_i && ctz_ie_i) |=> (ctz_f && pend_q));
   // R3
   fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !act_i) |-> (en_clr_o ##1 halt_f));
   // R4
   abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> bus_f);
   // R8
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctz_i && clr_i[B_CTZ]) |=> ctz_f);
   // R10
   no_flag_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctz_f && !rld_f && !bus_f && !halt_f && !to_f) |-> !pend_q);
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_CH-1:0]      ch_active_i,
   input  logic [NUM_CH-1:0]      ctz_evt_i,
   input  logic [NUM_CH-1:0]      rld_evt_i,
   input  logic [NUM_CH-1:0]      to_evt_i,
   input  logic [NUM_CH-1:0]      abort_evt_i,
   input  logic [NUM_CH-1:0]      ctz_ie_i,
   input  logic [NUM_CH-1:0]      dis_ie_i,
   input  logic [NUM_CH-1:0]      glb_ie_i,
   input  logic                   wr_en_i,
   input  logic [CH_W-1:0]        wr_ch_i,
   input  logic [ST_W-1:0]        wr_data_i,
   output logic [NUM_CH*ST_W-1:0] st_o,
   output logic [NUM_CH-1:0]      irq_o,
   output logic [NUM_CH-1:0]      en_clr_o
);
   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_cfg
      $error("dma_irq_aggregator: NUM_CH must be 1..32");
   end

   logic [NUM_CH-1:0][ST_W-1:0] clr;
   logic [NUM_CH-1:0]           pend;

   dma_irq_wdec #(.NUM_CH(NUM_CH)) wdec_i (
      .wr_en_i  (wr_en_i),
      .wr_ch_i  (wr_ch_i),
      .wr_data_i(wr_data_i),
      .clr_o    (clr)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_irq_chan chan_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .act_i   (ch_active_i[c]),
         .ctz_i   (ctz_evt_i[c]),
         .rld_i   (rld_evt_i[c]),
         .to_i    (to_evt_i[c]),
         .abort_i (abort_evt_i[c]),
         .ctz_ie_i(ctz_ie_i[c]),
         .dis_ie_i(dis_ie_i[c]),
         .clr_i   (clr[c]),
         .st_o    (st_o[c*ST_W +: ST_W]),
         .pend_o  (pend[c]),
         .en_clr_o(en_clr_o[c])
      );
   end

   assign irq_o = pend & glb_ie_i;

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_o & ~glb_ie_i) == '0));
endmodule

// File: tb/dma_irq_aggregator_tb_top.sv
module dma_irq_aggregator_tb_top;
   localparam int N = 8;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0] act = '0, ctz = '0, rld = '0, to = '0, abt = '0;
   logic [N-1:0] cie = '0, die = '0, gie = '0;
   logic wr_en = 1'b0;
   logic [2:0] wr_ch = '0;
   logic [7:0] wr_data = '0;
   logic [N*8-1:0] st;
   logic [N-1:0] irq, enc;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   dma_irq_aggregator #(.NUM_CH(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .ch_active_i(act), .ctz_evt_i(ctz),
      .rld_evt_i(rld), .to_evt_i(to), .abort_evt_i(abt), .ctz_ie_i(cie),
      .dis_ie_i(die), .glb_ie_i(gie), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
      .wr_data_i(wr_data), .st_o(st), .irq_o(irq), .en_clr_o(enc)
   );

   task automatic chk(string req, logic [63:0] actv, logic [63:0] expv);
      checks++;
      if (actv !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, actv, expv);
      end
   endtask

   function automatic logic [7:0] stw(int c);
      return st[c*8 +: 8];
   endfunction

   task automatic tick(); @(negedge clk); endtask

   task automatic wclr(int c, logic [7:0] m);
      wr_en = 1'b1; wr_ch = 3'(c); wr_data = m;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic t_reset();
      chk("R1 status", st, '0);
      chk("R1 irq", irq, '0);
      chk("R1 en_clr", enc, '0);
   endtask

   task automatic t_ctz();
      cie[2] = 1'b1;
      ctz[2] = 1'b1; tick(); ctz[2] = 1'b0;
      chk("R2 ctz+pend", stw(2), 8'h06);
      chk("R9 gated off", irq[2], 1'b0);
      gie[2] = 1'b1; #1;
      chk("R9 gated on", irq[2], 1'b1);
      wclr(2, 8'h04);
      chk("R10 cleared", stw(2), 8'h00);
      chk("R10 irq drop", irq[2], 1'b0);
      cie[2] = 1'b0; gie[2] = 1'b0;
   endtask

   task automatic t_fall();
      die[3] = 1'b1;
      act[3] = 1'b1; tick();
      chk("R6 active", stw(3), 8'h01);
      act[3] = 1'b0; #1;
      chk("R3 en_clr", enc, 8'h08);
      tick();
      chk("R3 halt+pend", stw(3), 8'h22);
      chk("R3 en_clr low", enc, 8'h00);
      wclr(3, 8'h20);
      chk("R7 halt cleared", stw(3), 8'h00);
      die[3] = 1'b0;
   endtask

   task automatic t_abort();
      abt[5] = 1'b1; #1;
      chk("R4 en_clr", enc, 8'h20);
      tick(); abt[5] = 1'b0;
      chk("R11 bus no pend", stw(5), 8'h10);
      die[5] = 1'b1; tick();
      chk("R4 bus pend", stw(5), 8'h12);
      wclr(5, 8'h10);
      chk("R4 cleared", stw(5), 8'h00);
      die[5] = 1'b0;
   endtask

   task automatic t_rld_to();
      cie[1] = 1'b1;
      rld[1] = 1'b1; to[1] = 1'b1; tick(); rld[1] = 1'b0; to[1] = 1'b0;
      chk("R5 rld+to", stw(1), 8'h4A);
      wclr(1, 8'h08);
      chk("R5 to only no pend", stw(1), 8'h40);
      wclr(1, 8'h40);
      chk("R5 cleared", stw(1), 8'h00);
      cie[1] = 1'b0;
   endtask

   task automatic t_w1c();
      cie[6] = 1'b1; cie[7] = 1'b1; gie = '1;
      ctz[6] = 1'b1; rld[6] = 1'b1; abt[6] = 1'b1; to[6] = 1'b1; ctz[7] = 1'b1;
      tick(); ctz = '0; rld = '0; abt = '0; to = '0;
      chk("R7 setup6", stw(6), 8'h5E);
      chk("R7 setup7", stw(7), 8'h06);
      wclr(6, 8'h83);
      chk("R7 ro bits", stw(6), 8'h5E);
      wclr(6, 8'h14);
      chk("R7 partial", stw(6), 8'h4A);
      chk("R10 irq holds", irq[6], 1'b1);
      chk("R7 other ch", stw(7), 8'h06);
      wclr(6, 8'h48);
      chk("R10 all clear", stw(6), 8'h00);
      chk("R10 irq6 drop", irq[7:6], 2'b10);
      wclr(7, 8'h7C);
      chk("R7 ch7 cleared", stw(7), 8'h00);
      cie = '0; gie = '0;
   endtask

   task automatic t_collide();
      cie[0] = 1'b1;
      ctz[0] = 1'b1; tick(); ctz[0] = 1'b0;
      ctz[0] = 1'b1; wr_en = 1'b1; wr_ch = 3'd0; wr_data = 8'h04;
      tick();
      ctz[0] = 1'b0; wr_en = 1'b0; wr_data = '0;
      chk("R8 event wins", stw(0), 8'h06);
      wclr(0, 8'h04);
      chk("R8 later clear", stw(0), 8'h00);
      cie[0] = 1'b0;
   endtask

   initial begin
      fork
         begin
            repeat (3) tick();
            t_reset();
            rst_n = 1'b1;
            tick();
            t_reset();
            t_ctz();
            t_fall();
            t_abort();
            t_rld_to();
            t_w1c();
            t_collide();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule